// File: doc/BRIEF.md
# Tagged Capability Memory

This block wraps an on-chip memory of 128-bit words and keeps one validity tag beside each word. Software cannot address the tag. It can only reach it through capability accesses. A capability store writes a whole aligned word and records the tag that came with the register value. A capability load returns the word and its tag in the same response. Ordinary data accesses work on one narrow lane of a word, chosen by the byte address and masked by byte enables. Any data store that writes at least one byte clears the word's tag in the same write. A plain integer therefore never becomes a valid capability.

Requests arrive on a valid/ready port and are served in order. Every accepted request produces exactly one response, one cycle later. A read issued right after a write sees the written data and tag. A capability access that is not on a 16-byte boundary is refused with an error and leaves memory untouched. Reset clears every tag. The data contents stay undefined after reset.

Top module: `capmem_tagged`

## Requirements
- R1: While `rst` is high, `req_ready` and `rsp_valid` are low. After reset, every word's tag reads as 0 until a capability store sets it.
- R2: A capability store (`req_op` = 2'b11) at an address with bits [3:0] = 0 writes all 128 bits of `req_wdata` to the word and sets the word's tag to `req_tag`.
- R3: A capability load (`req_op` = 2'b10) at an address with bits [3:0] = 0 returns the stored 128-bit word on `rsp_data` and its tag on `rsp_tag`.
- R4: A data store (`req_op` = 2'b01) with at least one bit of `req_be` set writes byte k of `req_wdata[31:0]` into byte k of 32-bit lane `req_addr[3:2]` of the word for each set `req_be[k]`. It clears the word's tag in the same write.
- R5: A data store (`req_op` = 2'b01) with `req_be` = 0 changes neither the word's data nor its tag.
- R6: A data load (`req_op` = 2'b00) returns lane `req_addr[3:2]` of the word in `rsp_data[31:0]`, with the upper bits and `rsp_tag` at 0. It does not alter the tag.
- R7: A capability access (`req_op[1]` = 1) with `req_addr[3:0]` not 0 gives a response with `rsp_err` = 1, `rsp_tag` = 0 and `rsp_data` = 0, and changes no data and no tag.
- R8: A load accepted in the cycle right after a store to the same word returns the data and tag that the store left.
- R9: Each request accepted (`req_valid` and `req_ready` high at a clock edge) gives exactly one `rsp_valid` pulse after the next edge. Stores give all-zero data and tag. `rsp_err` is 0 except in the R7 case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_op | input | 2 | 00 data load, 01 data store, 10 capability load, 11 capability store |
| req_addr | input | $clog2(DEPTH)+4 | Byte address |
| req_be | input | DATA_W/8 | Byte enables for data stores |
| req_wdata | input | 128 | Store data; data stores use the low DATA_W bits |
| req_tag | input | 1 | Tag of the stored capability |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Misaligned capability access |
| rsp_data | output | 128 | Load data |
| rsp_tag | output | 1 | Tag returned by a capability load |

## Verification
Two things land on one clock edge: the byte write of a partial data store and the clearing of that word's tag. The bench also exercises a third case, where a load issued in the very next cycle must see the merged result. Directed cases set a tag with a capability store, send a data store with one byte enabled, and then issue a capability load back to back. The load must return the merged bytes with the tag at 0. A store with no byte enabled must leave the tag at 1. Random traffic with back-to-back requests to a small set of words repeats these collisions many times. Each response is judged against a bench model of data and tags.

// File: rtl/capmem_pkg.sv
package capmem_pkg;
   localparam int CAP_W     = 128;
   localparam int CAP_BYTES = CAP_W / 8;
   localparam int OFS_W     = $clog2(CAP_BYTES);

   typedef enum logic [1:0] {
      OP_DLOAD  = 2'b00,
      OP_DSTORE = 2'b01,
      OP_CLOAD  = 2'b10,
      OP_CSTORE = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      RK_NONE = 2'b00,
      RK_DATA = 2'b01,
      RK_CAP  = 2'b10
   } rsp_kind_e;
endpackage

// File: rtl/capmem_decode.sv
module capmem_decode
   import capmem_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 32,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int AW     = IDX_W + OFS_W,
   localparam int LBYTES = DATA_W / 8,
   localparam int LANES  = CAP_W / DATA_W,
   localparam int LB_W   = $clog2(LBYTES),
   localparam int LSEL_W = $clog2(LANES)
) (
   input  logic                 acc,
   input  logic [1:0]           op,
   input  logic [AW-1:0]        addr,
   input  logic [LBYTES-1:0]    be,
   input  logic [CAP_W-1:0]     wdata,
   input  logic                 wtag,
   output logic [IDX_W-1:0]     idx,
   output logic [LSEL_W-1:0]    lane,
   output logic [CAP_BYTES-1:0] byte_we,
   output logic [CAP_W-1:0]     wline,
   output logic                 tag_we,
   output logic                 tag_wval,
   output logic                 rd_en,
   output logic                 err,
   output rsp_kind_e            kind
);
   op_e  op_q;
   logic misal;

   assign op_q  = op_e'(op);
   assign idx   = addr[AW-1:OFS_W];
   assign lane  = addr[LB_W +: LSEL_W];
   assign misal = (addr[OFS_W-1:0] != '0);

   always_comb begin
      byte_we  = '0;
      wline    = wdata;
      tag_we   = 1'b0;
      tag_wval = 1'b0;
      rd_en    = 1'b0;
      err      = 1'b0;
      kind     = RK_NONE;
      if (acc) begin
         unique case (op_q)
            OP_CSTORE: begin
               if (misal) err = 1'b1;
               else begin
                  byte_we  = '1;
                  tag_we   = 1'b1;
                  tag_wval = wtag;
               end
            end
            OP_CLOAD: begin
               if (misal) err = 1'b1;
               else begin
                  rd_en = 1'b1;
                  kind  = RK_CAP;
               end
            end
            OP_DSTORE: begin
               wline = {LANES{wdata[DATA_W-1:0]}};
               for (int l = 0; l < LANES; l++)
                  for (int k = 0; k < LBYTES; k++)
                     byte_we[l*LBYTES+k] = (lane == LSEL_W'(l)) && be[k];
               tag_we   = |be;
               tag_wval = 1'b0;
            end
            default: begin
               rd_en = 1'b1;
               kind  = RK_DATA;
            end
         endcase
      end
   end
endmodule

// File: rtl/capmem_data_ram.sv
module capmem_data_ram
   import capmem_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic [IDX_W-1:0]     idx,
   input  logic [CAP_BYTES-1:0] byte_we,
   input  logic [CAP_W-1:0]     wline,
   input  logic                 rd_en,
   output logic [CAP_W-1:0]     rd_data
);
   for (genvar b = 0; b < CAP_BYTES; b++) begin : g_byte
      logic [7:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (byte_we[b]) mem[idx] <= wline[b*8 +: 8];
         if (rd_en)      rd_data[b*8 +: 8] <= mem[idx];
      end
   end
endmodule

// File: rtl/capmem_tag_ram.sv
module capmem_tag_ram #(
   parameter int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] idx,
   input  logic             we,
   input  logic             wval,
   input  logic             rd_en,
   output logic             rd_tag
);
   logic [DEPTH-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         tag_q  <= '0;
         rd_tag <= 1'b0;
      end else begin
         if (we)    tag_q[idx] <= wval;
         if (rd_en) rd_tag     <= tag_q[idx];
      end
   end

   // R1: every tag is clear when reset is released
   a_r1_tags_cleared: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (tag_q == '0));
   // R4: a clearing write leaves the addressed tag at 0
   a_r4_tag_clear: assert property (@(posedge clk) disable iff (rst)
      (we && !wval) |=> !tag_q[$past(idx)]);
   // R2: a setting write leaves the addressed tag at 1
   a_r2_tag_set: assert property (@(posedge clk) disable iff (rst)
      (we && wval) |=> tag_q[$past(idx)]);
   // R6: a read alone never changes the tag store
   a_r6_read_keeps_tags: assert property (@(posedge clk) disable iff (rst)
      (!we) |=> $stable(tag_q));
endmodule

// File: rtl/capmem_tagged.sv
module capmem_tagged
   import capmem_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 32,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int AW     = IDX_W + OFS_W,
   localparam int LBYTES = DATA_W / 8,
   localparam int LANES  = CAP_W / DATA_W,
   localparam int LSEL_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [AW-1:0]     req_addr,
   input  logic [LBYTES-1:0] req_be,
   input  logic [CAP_W-1:0]  req_wdata,
   input  logic              req_tag,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [CAP_W-1:0]  rsp_data,
   output logic              rsp_tag
);
   initial begin
      assert (DEPTH >= 2 && (1 << IDX_W) == DEPTH) else $error("DEPTH must be a power of two");
      assert (DATA_W >= 8 && DATA_W < CAP_W && CAP_W % DATA_W == 0 && DATA_W % 8 == 0)
         else $error("DATA_W must be a byte multiple dividing the word");
      assert ((1 << LSEL_W) == LANES) else $error("lane count must be a power of two");
   end

   logic                 acc;
   logic [IDX_W-1:0]     idx;
   logic [LSEL_W-1:0]    lane, lane_q;
   logic [CAP_BYTES-1:0] byte_we;
   logic [CAP_W-1:0]     wline, rd_data;
   logic                 tag_we, tag_wval, rd_en, err, rd_tag;
   rsp_kind_e            kind, kind_q;
   logic                 ready_q, valid_q, err_q;

   assign acc = req_valid && ready_q;

   capmem_decode #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dec (
      .acc(acc), .op(req_op), .addr(req_addr), .be(req_be), .wdata(req_wdata),
      .wtag(req_tag), .idx(idx), .lane(lane), .byte_we(byte_we), .wline(wline),
      .tag_we(tag_we), .tag_wval(tag_wval), .rd_en(rd_en), .err(err), .kind(kind));

   capmem_data_ram #(.DEPTH(DEPTH)) u_data (
      .clk(clk), .idx(idx), .byte_we(byte_we), .wline(wline),
      .rd_en(rd_en), .rd_data(rd_data));

   capmem_tag_ram #(.DEPTH(DEPTH)) u_tag (
      .clk(clk), .rst(rst), .idx(idx), .we(tag_we), .wval(tag_wval),
      .rd_en(rd_en), .rd_tag(rd_tag));

   always_ff @(posedge clk) begin
      if (rst) begin
         ready_q <= 1'b0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         kind_q  <= RK_NONE;
         lane_q  <= '0;
      end else begin
         ready_q <= 1'b1;
         valid_q <= acc;
         err_q   <= err;
         kind_q  <= kind;
         lane_q  <= lane;
      end
   end

   always_comb begin
      rsp_data = '0;
      rsp_tag  = 1'b0;
      unique case (kind_q)
         RK_CAP: begin
            rsp_data = rd_data;
            rsp_tag  = rd_tag;
         end
         RK_DATA: rsp_data = CAP_W'(rd_data[lane_q*DATA_W +: DATA_W]);
         default: ;
      endcase
   end

   assign req_ready = ready_q;
   assign rsp_valid = valid_q;
   assign rsp_err   = err_q;

   // R9: one response per accepted request, none otherwise
   a_r9_one_rsp: assert property (@(posedge clk) disable iff (rst)
      acc |=> rsp_valid);
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !acc |=> !rsp_valid);
   // R7: misaligned capability access is refused
   a_r7_misaligned_err: assert property (@(posedge clk) disable iff (rst)
      (acc && req_op[1] && req_addr[OFS_W-1:0] != '0) |=> (rsp_err && !rsp_tag && rsp_data == '0));
   // R6: data loads never carry a tag or bits above the lane
   a_r6_dload_plain: assert property (@(posedge clk) disable iff (rst)
      (acc && req_op == 2'b00) |=> (!rsp_tag && rsp_data[CAP_W-1:DATA_W] == '0));
   // R1: nothing accepted or answered while reset is applied
   a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!req_ready && !rsp_valid));
endmodule

// File: tb/sim_capmem_tagged.sv
`timescale 1ns/1ps
module sim_capmem_tagged;
   localparam int DEPTH  = 64;
   localparam int DATA_W = 32;
   localparam int IDX_W  = $clog2(DEPTH);
   localparam int AW     = IDX_W + 4;
   localparam int LB     = DATA_W / 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [1:0] req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [LB-1:0] req_be = '0;
   logic [127:0] req_wdata = '0;
   logic req_tag = 1'b0;
   logic rsp_valid, rsp_err, rsp_tag;
   logic [127:0] rsp_data;

   always #4 clk = ~clk;

   capmem_tagged #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_data(rsp_data), .rsp_tag(rsp_tag));

   logic [127:0] mem_m [DEPTH];
   logic         tag_m [DEPTH];
   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;
   bit done    = 0;

   task automatic chk(input string rq, input logic [130:0] act, input logic [130:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   function automatic logic [130:0] expect_rsp(input logic [1:0] op, input logic [AW-1:0] a,
         input logic [LB-1:0] be, input logic [127:0] wd, input logic tg);
      logic [IDX_W-1:0] ix;
      logic [1:0] ln;
      logic [130:0] r;
      ix = a[AW-1:4];
      ln = a[3:2];
      r  = {1'b1, 130'b0};
      if (op[1] && a[3:0] != 4'd0) r[129] = 1'b1;
      else begin
         case (op)
            2'b11: begin mem_m[ix] = wd; tag_m[ix] = tg; end
            2'b10: r[128:0] = {tag_m[ix], mem_m[ix]};
            2'b01: begin
               for (int k = 0; k < LB; k++)
                  if (be[k]) mem_m[ix][ln*DATA_W + k*8 +: 8] = wd[k*8 +: 8];
               if (be != '0) tag_m[ix] = 1'b0;
            end
            default: r[127:0] = 128'(mem_m[ix][ln*DATA_W +: DATA_W]);
         endcase
      end
      return r;
   endfunction

   task automatic req(input logic [1:0] op, input logic [AW-1:0] a, input logic [LB-1:0] be,
         input logic [127:0] wd, input logic tg, input string rq, input bit skip_data = 0);
      logic [130:0] e, got;
      req_valid = 1'b1; req_op = op; req_addr = a; req_be = be; req_wdata = wd; req_tag = tg;
      e = expect_rsp(op, a, be, wd, tg);
      @(negedge clk);
      got = {rsp_valid, rsp_err, rsp_tag, rsp_data};
      if (skip_data) begin got[127:0] = '0; e[127:0] = '0; end
      chk(rq, got, e);
   endtask

   task automatic idle(input string rq);
      req_valid = 1'b0;
      @(negedge clk);
      chk(rq, {rsp_valid, 130'b0}, 131'b0);
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   initial begin
      logic [AW-1:0] a;
      logic [1:0] op;
      string rq;
      void'($urandom(32'h5eed_c0de));
      for (int i = 0; i < DEPTH; i++) tag_m[i] = 1'b0;
      repeat (3) @(negedge clk);
      // R1: quiet port during reset
      chk("R1 reset", {req_ready, rsp_valid, 129'b0}, 131'b0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 ready after reset", {req_ready, 130'b0}, {1'b1, 130'b0});
      // R1: tags read 0 before any store (data undefined, not compared)
      req(2'b10, AW'(5 << 4), '0, '0, 1'b0, "R1 tag clear", 1);
      req(2'b10, AW'(63 << 4), '0, '0, 1'b0, "R1 tag clear", 1);
      // fill every word: R2
      for (int i = 0; i < DEPTH; i++) req(2'b11, AW'(i << 4), '0, rnd128(), 1'(i[0]), "R2 fill");
      // R2/R3: store tagged, load back-to-back (R8)
      req(2'b11, AW'(7 << 4), '0, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 1'b1, "R2 cstore");
      req(2'b10, AW'(7 << 4), '0, '0, 1'b0, "R8 R3 cload after cstore");
      // R5: zero byte enables change nothing
      req(2'b01, AW'((7 << 4) + 8), 4'b0000, 128'hdead_beef, 1'b0, "R5 empty dstore");
      req(2'b10, AW'(7 << 4), '0, '0, 1'b0, "R5 cload unchanged");
      // R4: one byte written, tag cleared in the same write, seen next cycle (R8)
      req(2'b01, AW'((7 << 4) + 4), 4'b0010, 128'h0000_aa00, 1'b0, "R4 dstore byte");
      req(2'b10, AW'(7 << 4), '0, '0, 1'b0, "R8 R4 cload merged untagged");
      // R6: data load returns lane, keeps tag
      req(2'b11, AW'(9 << 4), '0, rnd128(), 1'b1, "R2 cstore");
      req(2'b00, AW'((9 << 4) + 12), '0, '0, 1'b0, "R6 dload lane3");
      req(2'b10, AW'(9 << 4), '0, '0, 1'b0, "R6 tag kept after dload");
      // R7: misaligned capability store and load
      req(2'b11, AW'((9 << 4) + 4), '0, rnd128(), 1'b0, "R7 misaligned cstore");
      req(2'b10, AW'((9 << 4) + 1), '0, '0, 1'b0, "R7 misaligned cload");
      req(2'b10, AW'(9 << 4), '0, '0, 1'b0, "R7 word unchanged");
      idle("R9 no response when idle");
      // random traffic on a few words
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(15) == 0) begin
            idle("R9 idle");
            continue;
         end
         op = 2'($urandom);
         a  = {IDX_W'($urandom_range(7) + 8), 4'($urandom)};
         if (op[1] && $urandom_range(7) != 0) a[3:0] = 4'd0;
         case (op)
            2'b00: rq = "R6 rnd dload";
            2'b01: rq = "R4 rnd dstore";
            2'b10: rq = "R3 rnd cload";
            default: rq = "R2 rnd cstore";
         endcase
         if (op[1] && a[3:0] != 4'd0) rq = "R7 rnd misaligned";
         req(op, a, 4'($urandom), rnd128(), 1'($urandom), rq);
      end
      idle("R9 final idle");
      finish_run();
   end
endmodule